// File: doc/BRIEF.md
# Multi-Rate Clock Divider Chain

This block takes one fast input clock (nominally 20 MHz) and derives the slower clocks used around a processor. A binary chain gives the 10 MHz, 5 MHz, 2.5 MHz and 1.25 MHz taps. The 2.5 MHz tap serves as the processor clock. A separate divide-by-five stage gives a 4 MHz clock with an uneven duty cycle. A 1 MHz clock is produced in one of two ways, chosen by a mode input.

In the default mode, the 1 MHz clock is the 4 MHz clock halved twice, so its edges line up with 4 MHz rising edges. In the legacy mode, the 1 MHz clock comes from the 10 MHz tap divided by ten, so it has no fixed phase relation to the 4 MHz clock. Every output is a registered level in the input clock domain. A synchronous, active-high reset clears all counters. The mode is captured only during reset.

Top module: `clk_div_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge. The cycle count k below starts at 1 on the first edge with `rst` low.
- R2: `clk_10m` is high after odd-numbered edges k and low after even ones, so it toggles on every input edge.
- R3: {`clk_1m25`,`clk_2m5`,`clk_5m`,`clk_10m`} equals k modulo 16. Bit 0 is `clk_10m` and bit 3 is `clk_1m25`, so each tap toggles when the tap below it falls.
- R4: `clk_4m` repeats with a period of exactly 5 input cycles.
- R5: `clk_4m` is high after edges where (k-1) mod 5 is 0 or 1, and low for the other 3 of each 5 cycles.
- R6: With mode 0 (default), `clk_1m` equals bit 1 of n = floor((k-1)/5)+1. It changes only on an edge where `clk_4m` rises, and its period is 20 cycles.
- R7: With mode 1 (legacy), `clk_1m` is high when ((k+1)/2, integer division) mod 10 is at least 5. Its period is 20 cycles, it is high for 10 of them, and it is first high after edge 9.
- R8: A change of `mode_sel` while `rst` is low has no effect on `clk_1m`. The mode value sampled during reset stays in force until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock (20 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| mode_sel | input | 1 | 1 MHz derivation: 0 = from 4 MHz, 1 = from 10 MHz divided by ten |
| clk_10m | output | 1 | Input divided by 2 |
| clk_5m | output | 1 | Input divided by 4 |
| clk_2m5 | output | 1 | Input divided by 8, processor clock |
| clk_1m25 | output | 1 | Input divided by 16 |
| clk_4m | output | 1 | Input divided by 5, high 2 of 5 cycles |
| clk_1m | output | 1 | 1 MHz clock from the selected scheme |

## Verification
The bench builds the block with its default parameters: a 4-tap binary chain, a divide-by-five stage high for two counts, and a ten-count legacy divider. With these values, a run of a few hundred cycles covers several full wraps of the 16-count chain, of the 5-cycle 4 MHz pattern and of both 20-cycle 1 MHz schemes. The same window covers the first-high cycle of each output after reset. The bench flips the mode input mid-run without a reset and confirms that the 1 MHz sequence does not change.

// File: rtl/clk_div_chain.sv
module clk_div_chain #(
  parameter int DIV_N    = 5,
  parameter int DIV_HIGH = 2,
  parameter int LEG_DIV  = 10
) (
  input  logic clk_in,
  input  logic rst,
  input  logic mode_sel,
  output logic clk_10m,
  output logic clk_5m,
  output logic clk_2m5,
  output logic clk_1m25,
  output logic clk_4m,
  output logic clk_1m
);
  localparam int TAPS  = 4;
  localparam int CW    = $clog2(DIV_N);
  localparam int LW    = $clog2(LEG_DIV);
  localparam int LHALF = LEG_DIV / 2;

  logic [TAPS-1:0] bin_q;
  logic [CW-1:0]   div5_q;
  logic            hi4_q;
  logic [1:0]      quad_q;
  logic [LW-1:0]   leg_q;
  logic            mode_hold;

  always_ff @(posedge clk_in) begin
    if (rst) bin_q <= '0;
    else     bin_q <= bin_q + 1'b1;
  end

  always_ff @(posedge clk_in) begin
    if (rst) begin
      div5_q <= '0;
      hi4_q  <= 1'b0;
    end else begin
      div5_q <= (div5_q == CW'(DIV_N - 1)) ? '0 : div5_q + 1'b1;
      hi4_q  <= (div5_q < CW'(DIV_HIGH));
    end
  end

  always_ff @(posedge clk_in) begin
    if (rst)                quad_q <= '0;
    else if (div5_q == '0)  quad_q <= quad_q + 1'b1;
  end

  always_ff @(posedge clk_in) begin
    if (rst)             leg_q <= '0;
    else if (!bin_q[0])  leg_q <= (leg_q == LW'(LEG_DIV - 1)) ? '0 : leg_q + 1'b1;
  end

  always_ff @(posedge clk_in) begin
    if (rst) mode_hold <= mode_sel;
  end

  assign clk_10m  = bin_q[0];
  assign clk_5m   = bin_q[1];
  assign clk_2m5  = bin_q[2];
  assign clk_1m25 = bin_q[3];
  assign clk_4m   = hi4_q;
  assign clk_1m   = mode_hold ? (leg_q >= LW'(LHALF)) : quad_q[1];
endmodule

module clk_div_chain_chk (
  input logic clk_in,
  input logic rst,
  input logic mode_hold,
  input logic clk_10m,
  input logic clk_5m,
  input logic clk_2m5,
  input logic clk_1m25,
  input logic clk_4m,
  input logic clk_1m
);
  p_reset_low_r1: assert property (@(posedge clk_in)
    rst |=> !(clk_10m | clk_5m | clk_2m5 | clk_1m25 | clk_4m | clk_1m));

  p_toggle10_r2: assert property (@(posedge clk_in) disable iff (rst)
    1'b1 |=> (clk_10m != $past(clk_10m)));

  p_chain5_r3: assert property (@(posedge clk_in) disable iff (rst)
    (clk_5m != $past(clk_5m)) |-> $fell(clk_10m));

  p_chain2m5_r3: assert property (@(posedge clk_in) disable iff (rst)
    (clk_2m5 != $past(clk_2m5)) |-> $fell(clk_5m));

  p_chain1m25_r3: assert property (@(posedge clk_in) disable iff (rst)
    (clk_1m25 != $past(clk_1m25)) |-> $fell(clk_2m5));

  p_high_two_r5: assert property (@(posedge clk_in) disable iff (rst)
    $rose(clk_4m) |=> clk_4m ##1 !clk_4m);

  p_low_three_r4: assert property (@(posedge clk_in) disable iff (rst)
    $fell(clk_4m) |=> !clk_4m ##1 !clk_4m ##1 clk_4m);

  p_lock_r6: assert property (@(posedge clk_in) disable iff (rst)
    (!mode_hold && (clk_1m != $past(clk_1m))) |-> $rose(clk_4m));

  p_mode_hold_r8: assert property (@(posedge clk_in) disable iff (rst)
    1'b1 |=> $stable(mode_hold));
endmodule

bind clk_div_chain clk_div_chain_chk u_chk (
  .clk_in(clk_in), .rst(rst), .mode_hold(mode_hold),
  .clk_10m(clk_10m), .clk_5m(clk_5m), .clk_2m5(clk_2m5), .clk_1m25(clk_1m25),
  .clk_4m(clk_4m), .clk_1m(clk_1m)
);

// File: tb/clk_div_chain_bench.sv
module clk_div_chain_bench;
  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic clk_10m, clk_5m, clk_2m5, clk_1m25, clk_4m, clk_1m;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_q[$];
  bit done = 1'b0;

  always #5 clk_in = ~clk_in;

  clk_div_chain u_clk_div_chain (
    .clk_in(clk_in), .rst(rst), .mode_sel(mode_sel),
    .clk_10m(clk_10m), .clk_5m(clk_5m), .clk_2m5(clk_2m5),
    .clk_1m25(clk_1m25), .clk_4m(clk_4m), .clk_1m(clk_1m)
  );

  function automatic logic [5:0] model(int k, bit legacy);
    logic [3:0] c;
    logic f4, f1;
    int n, m;
    c  = 4'(k % 16);
    f4 = ((k - 1) % 5) < 2;
    n  = (k - 1) / 5 + 1;
    m  = ((k + 1) / 2) % 10;
    f1 = legacy ? (m >= 5) : ((n % 4) >= 2);
    return {f1, f4, c[3], c[2], c[1], c[0]};
  endfunction

  task automatic check_bit(logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", what, act, exp);
    end
  endtask

  always @(posedge clk_in) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      e = exp_q.pop_front();
      check_bit(clk_10m,  e[0], "R2 clk_10m");
      check_bit(clk_5m,   e[1], "R3 clk_5m");
      check_bit(clk_2m5,  e[2], "R3 clk_2m5");
      check_bit(clk_1m25, e[3], "R3 clk_1m25");
      check_bit(clk_4m,   e[4], "R4/R5 clk_4m");
      check_bit(clk_1m,   e[5], "R6/R7/R8 clk_1m");
    end
  end

  task automatic reset_with(bit m);
    @(negedge clk_in);
    rst = 1'b1;
    mode_sel = m;
    repeat (3) @(posedge clk_in);
    @(negedge clk_in);
    check_bit(clk_10m | clk_5m | clk_2m5 | clk_1m25 | clk_4m | clk_1m, 1'b0, "R1 outputs in reset");
    rst = 1'b0;
  endtask

  task automatic drive(int n, bit legacy, int flip_at);
    for (int k = 1; k <= n; k++) begin
      if (k == flip_at) mode_sel = ~mode_sel;
      exp_q.push_back(model(k, legacy));
      @(posedge clk_in);
      @(negedge clk_in);
    end
  endtask

  initial begin
    reset_with(1'b0);
    drive(100, 1'b0, 0);
    reset_with(1'b1);
    drive(100, 1'b1, 0);
    reset_with(1'b0);
    drive(80, 1'b0, 23);
    reset_with(1'b1);
    drive(80, 1'b1, 37);
    @(posedge clk_in);
    #3;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_in);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule